// File: doc/BRIEF.md
# Automatic Input Level Controller

This block steers the gain code of an input programmable-gain stage from the digital side. It receives signed audio samples, each marked by a one-cycle valid pulse, and compares the magnitude of each sample with a programmable threshold. A sample above the threshold arms an attenuation. The attenuation is committed at the next zero crossing of the waveform, or when a selectable zero-crossing timeout runs out. After the input has stayed quiet for a programmable wait period, the block arms a small gain increase. That increase uses the same zero-crossing rule, and the gain climbs step by step toward a reference code that it never exceeds.

The gain code has seven bits. Code 00h stands for −8.0 dB and each step adds 0.5 dB, so 47h is +27.5 dB. When the controller is disabled, the host's own gain code drives the output directly. The wait and timeout periods are powers of two counted in samples. Two parameters set their base values.

Top module: `alc_gain_ctrl`

## Requirements
- R1: `gain_code` always lies in 00h..47h (00h = −8.0 dB, +0.5 dB per code). A host or reference code above 47h is treated as 47h.
- R2: While `rst_n` is low at a clock edge, the gain code is loaded with the (clamped) reference code, and all armed changes and counters are cleared.
- R3: With `alc_en` low, `gain_code` equals the clamped `host_gain` one cycle later, and samples have no effect on it.
- R4: A valid sample whose magnitude is strictly above `lim_thr` arms an attenuation. The attenuation lowers the gain by `att_sel`+1 codes (att_sel 0..3 gives 1..4 codes), with a floor at 00h. It is applied at the next zero crossing, which is a change of the sign bit (bit 15) between two consecutive valid samples.
- R5: An armed change that sees no zero crossing is forced on the T-th valid sample after it was armed, where T = 2^(ZTO_BASE_LOG2 + `zto_sel`).
- R6: Each run of W valid samples that are not above the threshold arms one recovery step, where W = 2^(WAIT_BASE_LOG2 + `wait_sel`). The step is armed only if no attenuation is armed and the gain is below the reference. The wait count restarts after each run of W.
- R7: A recovery step raises the gain by 1 code (`rec_sel`=0) or 2 codes (`rec_sel`=1), capped at the reference code. It is applied under the same zero-crossing and timeout rule as R4 and R5.
- R8: A sample above the threshold cancels an armed recovery on that same sample, restarts the wait count and arms an attenuation. No recovery step is applied on that sample.
- R9: While enabled, `gain_code` changes only in the cycle after a valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle pulse marking a new sample |
| smp_data | input | 16 | Signed sample, two's complement |
| alc_en | input | 1 | Enable automatic control; low selects host gain |
| lim_thr | input | 16 | Magnitude threshold for the limiter |
| ref_gain | input | 7 | Reference (maximum recovery) gain code |
| host_gain | input | 7 | Gain code used while disabled |
| wait_sel | input | 2 | Quiet-period select for recovery |
| zto_sel | input | 2 | Zero-crossing timeout select |
| att_sel | input | 2 | Attenuation step select |
| rec_sel | input | 1 | Recovery step select |
| gain_code | output | 7 | Gain code to the analog stage |

## Verification
The limiter and the recovery can both act on one sample: an over-threshold sample can arrive while a recovery step is armed and a zero crossing occurs in the same sample. The stimulus table provokes exactly that case. It first lets a wait period arm a recovery, then feeds a loud sample of opposite sign. The gain must stay unchanged on that sample, and the later forced attenuation must then lower it by the attenuation step. A second coincidence comes from a loud sample that crosses zero while an attenuation is already armed. That sample must commit the armed attenuation and arm a fresh one, so that the next crossing lowers the gain again.

// File: rtl/alc_pkg.sv
package alc_pkg;

    localparam int unsigned GAIN_W   = 7;
    localparam logic [GAIN_W-1:0] GAIN_TOP = 7'h47;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              lim_pend;
        logic              rec_pend;
    } alc_ctl_t;

    function automatic logic [GAIN_W-1:0] clamp_code(input logic [GAIN_W-1:0] c);
        return (c > GAIN_TOP) ? GAIN_TOP : c;
    endfunction

    function automatic logic [2:0] att_codes(input logic [1:0] sel);
        return {1'b0, sel} + 3'd1;
    endfunction

    function automatic logic [2:0] rec_codes(input logic sel);
        return sel ? 3'd2 : 3'd1;
    endfunction

endpackage

// File: rtl/alc_level_det.sv
module alc_level_det #(
    parameter int unsigned SW = 16
) (
    input  logic [SW-1:0] smp,
    input  logic [SW-1:0] thr,
    output logic          over
);
    logic [SW:0] ext;
    logic [SW:0] mag;

    always_comb begin
        ext  = {smp[SW-1], smp};
        mag  = smp[SW-1] ? (~ext + 1'b1) : ext;
        over = (mag > {1'b0, thr});
    end
endmodule

// File: rtl/alc_zc_det.sv
module alc_zc_det (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic valid,
    input  logic sign_in,
    output logic zc
);
    typedef struct packed {
        logic have;
        logic sign;
    } zc_st_t;

    zc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (valid) begin
            st_d.have = 1'b1;
            st_d.sign = sign_in;
        end
        zc = en && valid && st_q.have && (sign_in != st_q.sign);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/alc_wait_timer.sv
module alc_wait_timer #(
    parameter int unsigned BASE_LOG2 = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       valid,
    input  logic       over,
    input  logic [1:0] sel,
    output logic       hit
);
    localparam int unsigned CW = BASE_LOG2 + 4;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] target;
    logic [CW-1:0] nxt;

    always_comb begin
        target = {{(CW-1){1'b0}}, 1'b1} << (BASE_LOG2 + 32'(sel));
        nxt    = cnt_q + 1'b1;
        hit    = en && valid && !over && (nxt == target);
        cnt_d  = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else if (valid) begin
            if (over || hit) cnt_d = '0;
            else             cnt_d = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/alc_zto_timer.sv
module alc_zto_timer #(
    parameter int unsigned BASE_LOG2 = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       valid,
    input  logic       active,
    input  logic       restart,
    input  logic       zc,
    input  logic [1:0] sel,
    output logic       apply
);
    localparam int unsigned CW = BASE_LOG2 + 4;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] target;
    logic [CW-1:0] nxt;
    logic          force_now;

    always_comb begin
        target    = {{(CW-1){1'b0}}, 1'b1} << (BASE_LOG2 + 32'(sel));
        nxt       = cnt_q + 1'b1;
        force_now = active && (nxt == target);
        apply     = en && valid && active && (zc || force_now);
        cnt_d     = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else if (valid) begin
            if (!active || apply || restart) cnt_d = '0;
            else                             cnt_d = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
    import alc_pkg::*;
#(
    parameter int unsigned SW             = 16,
    parameter int unsigned WAIT_BASE_LOG2 = 7,
    parameter int unsigned ZTO_BASE_LOG2  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_data,
    input  logic          alc_en,
    input  logic [SW-1:0] lim_thr,
    input  logic [6:0]    ref_gain,
    input  logic [6:0]    host_gain,
    input  logic [1:0]    wait_sel,
    input  logic [1:0]    zto_sel,
    input  logic [1:0]    att_sel,
    input  logic          rec_sel,
    output logic [6:0]    gain_code
);
    alc_ctl_t ctl_d, ctl_q;

    logic       over;
    logic       zc;
    logic       hit;
    logic       apply;
    logic       active;
    logic       restart;
    logic [6:0] ref_c;
    logic [6:0] host_c;
    logic [2:0] att;
    logic [2:0] rec;
    logic [7:0] up;

    alc_level_det #(.SW(SW)) u_lvl (
        .smp  (smp_data),
        .thr  (lim_thr),
        .over (over)
    );

    alc_zc_det u_zc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (alc_en),
        .valid   (smp_valid),
        .sign_in (smp_data[SW-1]),
        .zc      (zc)
    );

    alc_wait_timer #(.BASE_LOG2(WAIT_BASE_LOG2)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (alc_en),
        .valid (smp_valid),
        .over  (over),
        .sel   (wait_sel),
        .hit   (hit)
    );

    alc_zto_timer #(.BASE_LOG2(ZTO_BASE_LOG2)) u_zto (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (alc_en),
        .valid   (smp_valid),
        .active  (active),
        .restart (restart),
        .zc      (zc),
        .sel     (zto_sel),
        .apply   (apply)
    );

    always_comb begin
        ref_c   = clamp_code(ref_gain);
        host_c  = clamp_code(host_gain);
        att     = att_codes(att_sel);
        rec     = rec_codes(rec_sel);
        up      = {1'b0, ctl_q.gain} + {5'b0, rec};
        active  = ctl_q.lim_pend || ctl_q.rec_pend;
        restart = over && !ctl_q.lim_pend;

        ctl_d = ctl_q;
        if (!alc_en) begin
            ctl_d.gain     = host_c;
            ctl_d.lim_pend = 1'b0;
            ctl_d.rec_pend = 1'b0;
        end else if (smp_valid) begin
            // commit an armed change: attenuation first, recovery only on a quiet sample
            if (apply && ctl_q.lim_pend) begin
                ctl_d.gain = (ctl_q.gain > {4'b0, att}) ? (ctl_q.gain - {4'b0, att}) : 7'h00;
            end else if (apply && ctl_q.rec_pend && !over && (ctl_q.gain < ref_c)) begin
                ctl_d.gain = (up >= {1'b0, ref_c}) ? ref_c : up[6:0];
            end

            if (over)                         ctl_d.lim_pend = 1'b1;
            else if (apply && ctl_q.lim_pend) ctl_d.lim_pend = 1'b0;

            if (over)                         ctl_d.rec_pend = 1'b0;
            else if (apply && ctl_q.rec_pend) ctl_d.rec_pend = 1'b0;
            else if (hit && !ctl_q.lim_pend && (ctl_q.gain < ref_c))
                                              ctl_d.rec_pend = 1'b1;
        end
        gain_code = ctl_q.gain;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.gain     <= clamp_code(ref_gain);
            ctl_q.lim_pend <= 1'b0;
            ctl_q.rec_pend <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/alc_gain_ctrl_chk.sv
module alc_gain_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_valid,
    input logic       alc_en,
    input logic [6:0] ref_gain,
    input logic [6:0] host_gain,
    input logic [6:0] gain_code
);
    logic [6:0] ref_lim;
    always_comb ref_lim = (ref_gain > 7'h47) ? 7'h47 : ref_gain;

    // R1
    gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_code <= 7'h47);

    // R2
    reset_load_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> gain_code == (($past(ref_gain) > 7'h47) ? 7'h47 : $past(ref_gain)));

    // R3
    host_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alc_en |=> gain_code == (($past(host_gain) > 7'h47) ? 7'h47 : $past(host_gain)));

    // R4
    att_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && $past(alc_en) && gain_code < $past(gain_code))
            |-> ($past(gain_code) - gain_code) <= 7'd4);

    // R7
    rec_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && $past(alc_en) && gain_code > $past(gain_code))
            |-> (gain_code <= ref_lim && (gain_code - $past(gain_code)) <= 7'd2));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && !smp_valid) |=> ($stable(gain_code) || !$past(alc_en)));
endmodule

bind alc_gain_ctrl alc_gain_ctrl_chk u_chk (.*);

// File: tb/sim_alc_gain_ctrl.sv
module sim_alc_gain_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic        alc_en;
    logic [15:0] lim_thr;
    logic [6:0]  ref_gain;
    logic [6:0]  host_gain;
    logic [1:0]  wait_sel;
    logic [1:0]  zto_sel;
    logic [1:0]  att_sel;
    logic        rec_sel;
    logic [6:0]  gain_code;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    alc_gain_ctrl #(.SW(16), .WAIT_BASE_LOG2(1), .ZTO_BASE_LOG2(1)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .alc_en(alc_en), .lim_thr(lim_thr), .ref_gain(ref_gain), .host_gain(host_gain),
        .wait_sel(wait_sel), .zto_sel(zto_sel), .att_sel(att_sel), .rec_sel(rec_sel),
        .gain_code(gain_code)
    );

    // {sample, expected gain after it}; thr 1000, ref 20h, step 2 down / 1 up, W=2, T=4
    localparam logic [22:0] VEC [24] = '{
        {16'(2000),  7'h20}, {16'(100),   7'h20}, {16'(-100),  7'h1E}, {16'(-100), 7'h1E},
        {16'(-100),  7'h1E}, {16'(-100),  7'h1E}, {16'(100),   7'h1F}, {16'(100),  7'h1F},
        {16'(100),   7'h1F}, {16'(100),   7'h1F}, {16'(100),   7'h1F}, {16'(100),  7'h1F},
        {16'(100),   7'h20}, {16'(100),   7'h20}, {16'(100),   7'h20}, {16'(5000), 7'h20},
        {16'(-5000), 7'h1E}, {16'(10),    7'h1C}, {16'(10),    7'h1C}, {16'(-2000),7'h1C},
        {16'(-10),   7'h1C}, {16'(-10),   7'h1C}, {16'(-10),   7'h1C}, {16'(-10),  7'h1A}
    };

    task automatic check(input logic [6:0] exp, input string tag);
        nchk++;
        if (gain_code !== exp) begin
            nfail++;
            $display("FAIL %s: gain_code actual %h expected %h", tag, gain_code, exp);
        end
    endtask

    task automatic send(input logic [15:0] s);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = s;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; alc_en = 1'b1;
        lim_thr = 16'd1000; ref_gain = 7'h20; host_gain = 7'h10;
        wait_sel = 2'd0; zto_sel = 2'd1; att_sel = 2'd1; rec_sel = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check(7'h20, "R2 reset loads reference");

        // R4 R5 R6 R7 R8 table walk
        for (int i = 0; i < 24; i++) begin
            send(VEC[i][22:7]);
            check(VEC[i][6:0], $sformatf("R4/R5/R6/R7/R8 vector %0d", i));
        end

        // R3: disabled follows host, samples ignored
        alc_en = 1'b0; host_gain = 7'h15;
        idle(2);
        check(7'h15, "R3 host gain while disabled");
        send(16'(-30000));
        send(16'(30000));
        check(7'h15, "R3 samples ignored while disabled");

        // R1: host code above range clamps
        host_gain = 7'h7F;
        idle(2);
        check(7'h47, "R1 host clamp to 47h");

        // R7: recovery step of 2 capped at reference
        host_gain = 7'h1F; rec_sel = 1'b1; wait_sel = 2'd0;
        idle(2);
        alc_en = 1'b1;
        idle(1);
        send(16'(10));
        send(16'(10));
        check(7'h1F, "R6 recovery armed not yet applied");
        send(16'(-10));
        check(7'h20, "R7 recovery capped at reference");

        // R4 floor and R5 shortest timeout
        alc_en = 1'b0; host_gain = 7'h02; att_sel = 2'd3; zto_sel = 2'd0;
        idle(2);
        alc_en = 1'b1;
        idle(1);
        send(16'(3000));
        send(16'(10));
        check(7'h02, "R5 no force before timeout");
        send(16'(10));
        check(7'h00, "R4 attenuation floors at 00h");
        idle(5);
        check(7'h00, "R9 no change without samples");

        // R2 with clamped reference
        ref_gain = 7'h50;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        check(7'h47, "R2 R1 reset loads clamped reference");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule